// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This block runs on the host side of a parallel flash device. It waits for an internal program or erase operation to finish. Software, or a command sequencer, first issues the command sequence. For an erase, that includes the last write pulse. It then pulses `start` with three things: a poll address, the byte that was programmed, and the operation type. The poll address is the programmed location, or for an erase an address inside a sector being erased, never a protected one.

From then on the engine repeatedly reads the device over a request/acknowledge read port and inspects each returned status byte. Bit 7 is the completion indicator: it reads as the inverse of the programmed bit 7, or as 0 during an erase, until the operation ends. Bit 5 reports that the device's internal time limit was exceeded. Because bit 7 may flip to true data at the same moment bit 5 rises, a set bit 5 triggers one more read before any verdict. Once bit 7 shows completion, the other bits of that same byte cannot yet be trusted, so the engine takes the data from one further read. A programmable limit on ordinary polls bounds the wait.

The outcome is a one-cycle `done` pulse together with a held `ok` or `err` level and the verified byte.

Top module: `flash_poll_engine`

## Requirements
- R1: A `start` pulse is accepted only when the engine is not busy (idle, or resting after a result). It captures `poll_addr`, `exp_data`, `erase_op` and `poll_limit`, clears `ok`, `err` and `result_data`, and raises `busy`. A `start` while busy has no effect on the running operation or its read address.
- R2: A read is requested by holding `rd_req` high with `rd_addr` constant until a cycle in which `rd_ack` is high. Every read of an operation uses the captured poll address.
- R3: Completion is indicated when bit 7 of a returned byte equals the target bit 7. For a program the target is bit 7 of `exp_data`; for an erase it is 1 and `exp_data` is ignored.
- R4: A poll whose bit 7 differs from the target and whose bit 5 is 0 is followed by another poll, unless the poll limit is spent.
- R5: A poll whose bit 7 differs and whose bit 5 is 1 is followed by exactly one re-read. If the re-read shows completion (R3), the engine proceeds to verification; otherwise it ends in failure.
- R6: After completion is seen, one further read is made, and that byte is presented on `result_data`. The result is success if it equals `exp_data` (program) or 8'hFF (erase), and failure otherwise.
- R7: With `poll_limit` = L (L = 0 treated as 1), only ordinary polls count. If the L-th poll neither completes nor shows bit 5, the engine fails without reading again. Re-reads and verification reads are not counted.
- R8: `done` is high for exactly one cycle, on entry to success or failure. In that cycle exactly one of `ok` and `err` is high, and it stays high until the next accepted `start`.
- R9: While `rst` is high and in the cycle after, `busy`, `done`, `rd_req`, `ok` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin polling (one-cycle pulse) |
| erase_op | input | 1 | 1 = erase operation, 0 = program operation |
| poll_addr | input | AW | Address to poll |
| exp_data | input | DW | Byte that was programmed |
| poll_limit | input | CW | Maximum number of ordinary polls |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | AW | Read address |
| rd_ack | input | 1 | Read data valid this cycle |
| rd_data | input | DW | Read data from the device |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Last operation succeeded |
| err | output | 1 | Last operation failed |
| result_data | output | DW | Byte from the verification read |

## Verification
The properties assume that the read port acknowledges only while `rd_req` is high, and that `rd_data` is valid in the acknowledge cycle. They also assume that `start` comes from a source that may pulse it at any time, including mid-operation. The bench's device model raises `rd_ack` only in response to a pending request, optionally stalling one cycle first. It serves scripted status bytes, so every returned byte belongs to a known phase of polling. The bench also deliberately pulses `start` during a busy run to probe R1 while keeping the handshake legal.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_CHECK7, ST_CHECK5,
    ST_REREAD, ST_VERIFY, ST_PASS, ST_FAIL
  } fpoll_state_e;

  localparam int POLL_BIT = 7;
  localparam int TLIM_BIT = 5;
endpackage

// File: rtl/fpoll_eval.sv
module fpoll_eval #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] sample,
  input  logic [DW-1:0] expect_byte,
  input  logic          erase,
  output logic          poll_match,
  output logic          tlimit_hit,
  output logic          byte_ok
);
  import fpoll_pkg::*;

  logic [DW-1:0] target;

  always_comb begin
    target     = erase ? {DW{1'b1}} : expect_byte;
    poll_match = (sample[POLL_BIT] == target[POLL_BIT]);
    tlimit_hit = sample[TLIM_BIT];
    byte_ok    = (sample == target);
  end
endmodule

// File: rtl/fpoll_budget.sv
module fpoll_budget #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          bump,
  input  logic [CW-1:0] limit,
  output logic          spent
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] used;
  logic [CW-1:0] eff_limit;

  always_ff @(posedge clk) begin
    if (rst || clear)
      used <= '0;
    else if (bump && used != {CW{1'b1}})
      used <= used + ONE;
  end

  always_comb begin
    eff_limit = (limit == '0) ? ONE : limit;
    spent     = (used >= eff_limit);
  end
endmodule

// File: rtl/flash_poll_engine.sv
module flash_poll_engine #(
  parameter int AW = 20,
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          erase_op,
  input  logic [AW-1:0] poll_addr,
  input  logic [DW-1:0] exp_data,
  input  logic [CW-1:0] poll_limit,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          done,
  output logic          ok,
  output logic          err,
  output logic [DW-1:0] result_data
);
  import fpoll_pkg::*;

  fpoll_state_e  state;
  logic [DW-1:0] exp_q;
  logic          erase_q;
  logic [CW-1:0] limit_q;
  logic          match_q;
  logic          tlim_q;
  logic          accept;
  logic          poll_match;
  logic          tlimit_hit;
  logic          byte_ok;
  logic          spent;
  logic          bump;

  assign accept = start && (state == ST_IDLE || state == ST_PASS || state == ST_FAIL);
  assign bump   = (state == ST_READ) && rd_ack;
  assign busy   = !(state == ST_IDLE || state == ST_PASS || state == ST_FAIL);

  fpoll_eval #(.DW(DW)) u_eval (
    .sample     (rd_data),
    .expect_byte(exp_q),
    .erase      (erase_q),
    .poll_match (poll_match),
    .tlimit_hit (tlimit_hit),
    .byte_ok    (byte_ok)
  );

  fpoll_budget #(.CW(CW)) u_budget (
    .clk  (clk),
    .rst  (rst),
    .clear(accept),
    .bump (bump),
    .limit(limit_q),
    .spent(spent)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      rd_req      <= 1'b0;
      rd_addr     <= '0;
      exp_q       <= '0;
      erase_q     <= 1'b0;
      limit_q     <= '0;
      match_q     <= 1'b0;
      tlim_q      <= 1'b0;
      done        <= 1'b0;
      ok          <= 1'b0;
      err         <= 1'b0;
      result_data <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE, ST_PASS, ST_FAIL: begin
          if (accept) begin
            rd_addr     <= poll_addr;
            exp_q       <= exp_data;
            erase_q     <= erase_op;
            limit_q     <= poll_limit;
            ok          <= 1'b0;
            err         <= 1'b0;
            result_data <= '0;
            rd_req      <= 1'b1;
            state       <= ST_READ;
          end
        end
        ST_READ: begin
          if (rd_ack) begin
            match_q <= poll_match;
            tlim_q  <= tlimit_hit;
            rd_req  <= 1'b0;
            state   <= ST_CHECK7;
          end
        end
        ST_CHECK7: begin
          if (match_q) begin
            rd_req <= 1'b1;
            state  <= ST_VERIFY;
          end else begin
            state  <= ST_CHECK5;
          end
        end
        ST_CHECK5: begin
          if (tlim_q) begin
            rd_req <= 1'b1;
            state  <= ST_REREAD;
          end else if (spent) begin
            err   <= 1'b1;
            done  <= 1'b1;
            state <= ST_FAIL;
          end else begin
            rd_req <= 1'b1;
            state  <= ST_READ;
          end
        end
        ST_REREAD: begin
          if (rd_ack) begin
            if (poll_match) begin
              state <= ST_VERIFY;
            end else begin
              rd_req <= 1'b0;
              err    <= 1'b1;
              done   <= 1'b1;
              state  <= ST_FAIL;
            end
          end
        end
        ST_VERIFY: begin
          if (rd_ack) begin
            result_data <= rd_data;
            rd_req      <= 1'b0;
            done        <= 1'b1;
            if (byte_ok) begin
              ok    <= 1'b1;
              state <= ST_PASS;
            end else begin
              err   <= 1'b1;
              state <= ST_FAIL;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpoll_chk.sv
module fpoll_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          rd_req,
  input logic          rd_ack,
  input logic [AW-1:0] rd_addr,
  input logic          busy,
  input logic          done,
  input logic          ok,
  input logic          err
);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ack) |=> rd_req);

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ack) |=> $stable(rd_addr));

  // R1
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(rd_addr));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_verdict_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (ok ^ err));

  // R8
  verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ok && err));

  // R9
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!busy && !done && !rd_req && !ok && !err));
endmodule

bind flash_poll_engine fpoll_chk #(.AW(AW)) u_fpoll_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .rd_req (rd_req),
  .rd_ack (rd_ack),
  .rd_addr(rd_addr),
  .busy   (busy),
  .done   (done),
  .ok     (ok),
  .err    (err)
);

// File: tb/flash_poll_engine_test.sv
module flash_poll_engine_test;
  localparam int AW = 20;
  localparam int DW = 8;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          erase_op = 1'b0;
  logic [AW-1:0] poll_addr = '0;
  logic [DW-1:0] exp_data = '0;
  logic [CW-1:0] poll_limit = '0;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_ack = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic          busy, done, ok, err;
  logic [DW-1:0] result_data;

  always #5 clk = ~clk;

  flash_poll_engine #(.AW(AW), .DW(DW), .CW(CW)) uut (
    .clk(clk), .rst(rst), .start(start), .erase_op(erase_op),
    .poll_addr(poll_addr), .exp_data(exp_data), .poll_limit(poll_limit),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .busy(busy), .done(done), .ok(ok), .err(err), .result_data(result_data)
  );

  typedef struct {
    string    name;
    logic     ok;
    logic     err;
    logic [7:0] data;
    int       reads;
  } exp_t;

  exp_t       sb_q[$];
  logic [7:0] resp_q[$];
  int         n_chk = 0;
  int         n_bad = 0;
  int         nreads = 0;
  logic [AW-1:0] cur_addr = '0;
  bit         stall_en = 0;
  bit         stall_hold = 0;
  bit         finished = 0;

  task automatic chk(input bit good, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // device model: answers pending requests on the falling edge
  always @(negedge clk) begin
    if (rd_req && !rst) begin
      if (stall_en && !stall_hold) begin
        stall_hold = 1;
        rd_ack <= 1'b0;
      end else begin
        stall_hold = 0;
        chk(rd_addr == cur_addr, "R2", "read address", int'(rd_addr), int'(cur_addr));
        rd_ack  <= 1'b1;
        rd_data <= (resp_q.size() > 0) ? resp_q.pop_front() : 8'h00;
        nreads++;
      end
    end else begin
      rd_ack <= 1'b0;
    end
  end

  // monitor: compares each completion against the scoreboard
  always @(negedge clk) begin
    if (done && !rst) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R8", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(ok == e.ok, "R6", {e.name, " ok"}, int'(ok), int'(e.ok));
        chk(err == e.err, "R8", {e.name, " err"}, int'(err), int'(e.err));
        chk(result_data == e.data, "R6", {e.name, " data"}, int'(result_data), int'(e.data));
        chk(nreads == e.reads, "R7", {e.name, " read count"}, nreads, e.reads);
      end
    end
  end

  task automatic run_case(input string name, input logic [AW-1:0] addr,
                          input logic [7:0] data, input bit erase,
                          input int limit, input logic [7:0] bytes[$],
                          input bit exp_ok, input logic [7:0] exp_res,
                          input int exp_reads, input bit poke_busy);
    exp_t e;
    int waited;
    e.name = name; e.ok = exp_ok; e.err = !exp_ok;
    e.data = exp_res; e.reads = exp_reads;
    @(negedge clk);
    resp_q = bytes;
    sb_q.push_back(e);
    nreads = 0;
    cur_addr = addr;
    poll_addr = addr; exp_data = data; erase_op = erase;
    poll_limit = CW'(limit);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1", {name, " busy after start"}, int'(busy), 1);
    if (poke_busy) begin
      // R1: a start during a run must not disturb it
      poll_addr = ~addr; exp_data = ~data; erase_op = ~erase;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waited = 0;
    while (!done && waited < 200) begin
      @(negedge clk);
      waited++;
    end
    chk(done == 1'b1, "R8", {name, " done seen"}, int'(done), 1);
    @(negedge clk);
    chk(done == 1'b0, "R8", {name, " done one cycle"}, int'(done), 0);
    chk(ok == exp_ok && err == !exp_ok, "R8", {name, " verdict held"},
        int'({ok, err}), int'({exp_ok, !exp_ok}));
    chk(busy == 1'b0, "R8", {name, " idle after done"}, int'(busy), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!busy && !done && !rd_req && !ok && !err, "R9", "state during reset",
        int'({busy, done, rd_req, ok, err}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !rd_req && !ok && !err, "R9", "state after reset",
        int'({busy, done, rd_req, ok, err}), 0);

    // R4 R3 R6: two busy polls, completion, then verified byte
    run_case("prog_pass", 20'h01234, 8'h5A, 0, 8, '{8'h80, 8'h80, 8'h5A, 8'h5A},
             1, 8'h5A, 4, 1);
    // R6: low bits invalid on the completing read, data taken from next read
    stall_en = 1;
    run_case("prog_lag", 20'h0ABCD, 8'h5A, 0, 8, '{8'h00, 8'h5A},
             1, 8'h5A, 2, 0);
    stall_en = 0;
    // R6: verification byte differs
    run_case("prog_bad", 20'h00010, 8'h5A, 0, 8, '{8'h00, 8'h4A},
             0, 8'h4A, 2, 0);
    // R5: bit 5 set, re-read shows completion
    run_case("tlim_recover", 20'h00020, 8'h5A, 0, 8, '{8'hA0, 8'h5A, 8'h5A},
             1, 8'h5A, 3, 0);
    // R5: bit 5 set, re-read still busy
    run_case("tlim_fail", 20'h00030, 8'h5A, 0, 8, '{8'hA0, 8'hA0},
             0, 8'h00, 2, 0);
    // R7: limit 3 exhausted
    run_case("limit3", 20'h00040, 8'h11, 0, 3, '{8'h80, 8'h80, 8'h80},
             0, 8'h00, 3, 0);
    // R7: limit 0 behaves as 1
    run_case("limit0", 20'h00050, 8'h11, 0, 0, '{8'h80},
             0, 8'h00, 1, 0);
    // R7: completion on the last allowed poll
    run_case("limit_edge", 20'h00060, 8'h5A, 0, 2, '{8'h80, 8'h5A, 8'h5A},
             1, 8'h5A, 3, 0);
    // R3: erase target bit 7 is 1, exp_data ignored
    stall_en = 1;
    run_case("erase_pass", 20'h70000, 8'h00, 1, 8, '{8'h00, 8'h80, 8'hFF},
             1, 8'hFF, 3, 1);
    stall_en = 0;
    // R6: erase verification must read all ones
    run_case("erase_bad", 20'h70004, 8'hFF, 1, 8, '{8'h80, 8'hFE},
             0, 8'hFE, 2, 0);

    chk(sb_q.size() == 0, "R8", "all results seen", sb_q.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule